// File: doc/BRIEF.md
# Programmable Sync Pulse Divider

This block makes the periodic synchronisation pulse that goes out with a 10 MHz reference and its 100 MHz companion clock. It runs on the fast clock. A one-cycle indication, `ref_tick`, marks each fast-clock cycle that lines up with a 10 MHz edge. Only those cycles can start a pulse, so the pulse always keeps its phase to the reference. The pulse is one fast-clock cycle wide and repeats once every n reference periods. n is a whole number from 1 to 255, so the pulse rate is 10/n MHz.

The divide ratio is loaded through a one-cycle write port. A new ratio is held aside and takes over only when the current period ends, so no period is ever cut short. A ratio of zero is refused.

A level input lets an outside timing source restart the divider, so that several chassis can bring their pulses into phase. The input first passes through a two-flop synchroniser. The restart then fires on the first reference edge after the synchronised level has been seen high, even if the level has already fallen by then. While the level stays high, the divider is held at its restart point and pulses on every reference edge. When the level falls, normal counting resumes.

Top module: `sync_pulse_divider`

## Requirements
- R1: After synchronous reset, `sync_pulse` is low and the ratio is 1. The first `ref_tick` after reset produces a pulse.
- R2: `sync_pulse` is high for exactly one clock cycle, and only in the cycle right after a cycle in which `ref_tick` was high.
- R3: With ratio n, a pulse follows every n-th `ref_tick`, counted from the previous pulse.
- R4: With the default ratio of 1, a pulse follows every `ref_tick`.
- R5: A write of value 0 on `ratio_data` with `ratio_wr` high is ignored: the stored ratio and the pulse spacing stay unchanged.
- R6: A written nonzero ratio takes effect at the next pulse. The period already running finishes with the old ratio.
- R7: `sync_ctrl` passes through two synchronising flops. Once the synchronised level has been high, the next `ref_tick` produces a pulse and restarts the count, even if `sync_ctrl` has already fallen.
- R8: While the synchronised `sync_ctrl` stays high, a pulse follows every `ref_tick`. After it falls, pulses come n ticks after the last forced pulse.
- R9: The largest ratio, 255 (`ratio_data` = 8'hFF), spaces pulses 255 ticks apart.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (100 MHz) clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | High for one cycle at each 10 MHz edge |
| sync_ctrl | input | 1 | Asynchronous restart level |
| ratio_wr | input | 1 | Write strobe for the divide ratio |
| ratio_data | input | RATIO_W | Divide ratio n to load |
| sync_pulse | output | 1 | Registered one-cycle sync pulse |

## Verification
Some rules are checked on every cycle:
- a pulse only ever follows a reference tick;
- the period counter stays below the active ratio;
- the active ratio changes only on a pulse;
- a zero write leaves the staged ratio alone;
- a tick seen while restart is asserted always yields a pulse.

Other behaviour needs the bench's scenarios to show it. This covers the actual pulse spacing for ratios 1, 3, 5 and 255, and the way a mid-period ratio change is deferred. It also covers the two-cycle synchroniser delay, a short restart level that falls before the tick arrives, and the way counting resumes after a long hold.

// File: rtl/sync_div_pkg.sv
package sync_div_pkg;
    localparam int DEF_RATIO_W = 8;

    // Per-tick decision of the divider core.
    typedef enum logic [1:0] {
        EV_IDLE    = 2'd0,
        EV_COUNT   = 2'd1,
        EV_WRAP    = 2'd2,
        EV_RESTART = 2'd3
    } tick_ev_e;

    function automatic tick_ev_e classify(input logic tick, input logic restart,
                                          input logic at_zero);
        if (!tick)        return EV_IDLE;
        else if (restart) return EV_RESTART;
        else if (at_zero) return EV_WRAP;
        else              return EV_COUNT;
    endfunction
endpackage

// File: rtl/sync_div_sync.sv
module sync_div_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= 1'b0;
                else if (i == 0) chain_q[i] <= d_async;
                else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sync_div_ratio.sv
module sync_div_ratio #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [RATIO_W-1:0] wdata,
    output logic [RATIO_W-1:0] staged
);
    localparam logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(1);

    always_ff @(posedge clk) begin
        if (rst) staged <= RESET_RATIO;
        else if (wr && (wdata != '0)) staged <= wdata;
    end

    // R5: a zero write leaves the staged ratio untouched
    a_r5_zero_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata == '0) |=> $stable(staged));
    a_r5_staged_nonzero: assert property (@(posedge clk) disable iff (rst)
        staged != '0);
endmodule

// File: rtl/sync_div_core.sv
module sync_div_core
    import sync_div_pkg::*;
#(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               restart_lvl,
    input  logic [RATIO_W-1:0] staged,
    output logic               pulse
);
    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] active_q;
    logic               armed_q;
    tick_ev_e           ev;

    assign ev = classify(tick, restart_lvl || armed_q, cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= ONE;
            armed_q  <= 1'b0;
            pulse    <= 1'b0;
        end else begin
            pulse <= 1'b0;
            unique case (ev)
                EV_IDLE: begin
                    if (restart_lvl) armed_q <= 1'b1;
                end
                EV_COUNT: begin
                    cnt_q <= cnt_q - ONE;
                end
                EV_WRAP, EV_RESTART: begin
                    cnt_q    <= staged - ONE;
                    active_q <= staged;
                    armed_q  <= 1'b0;
                    pulse    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R2: a pulse only ever follows a reference tick
    a_r2_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(tick));
    // R3: the count never reaches the active ratio
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q < active_q);
    // R6: the ratio in use changes only together with a pulse
    a_r6_switch_on_pulse: assert property (@(posedge clk) disable iff (rst)
        (active_q != $past(active_q)) |-> pulse);
    // R7: a tick seen during a restart always yields a pulse
    a_r7_restart_pulses: assert property (@(posedge clk) disable iff (rst)
        (tick && restart_lvl) |=> pulse);
endmodule

// File: rtl/sync_pulse_divider.sv
module sync_pulse_divider
    import sync_div_pkg::*;
#(
    parameter int RATIO_W     = DEF_RATIO_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_tick,
    input  logic               sync_ctrl,
    input  logic               ratio_wr,
    input  logic [RATIO_W-1:0] ratio_data,
    output logic               sync_pulse
);
    logic               restart_lvl;
    logic [RATIO_W-1:0] staged;

    sync_div_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_async(sync_ctrl), .q_sync(restart_lvl)
    );

    sync_div_ratio #(.RATIO_W(RATIO_W)) u_ratio (
        .clk(clk), .rst(rst), .wr(ratio_wr), .wdata(ratio_data), .staged(staged)
    );

    sync_div_core #(.RATIO_W(RATIO_W)) u_core (
        .clk(clk), .rst(rst), .tick(ref_tick), .restart_lvl(restart_lvl),
        .staged(staged), .pulse(sync_pulse)
    );

    // R1: output is quiet in the cycle right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !sync_pulse);
endmodule

// File: tb/sync_pulse_divider_tb_top.sv
module sync_pulse_divider_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       ref_tick;
    logic       sync_ctrl;
    logic       ratio_wr;
    logic [7:0] ratio_data;
    logic       sync_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit    q_exp[$];
    string q_req[$];
    bit    running = 1'b0;

    // Requirement-level model state
    int    m_n    = 1;
    int    m_next = 1;
    int    m_left = 0;
    bit    m_s0 = 0, m_s1 = 0, m_armed = 0;
    int    phase = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    sync_pulse_divider dut_i (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .sync_ctrl(sync_ctrl),
        .ratio_wr(ratio_wr), .ratio_data(ratio_data), .sync_pulse(sync_pulse)
    );

    task automatic check(input bit got, input bit exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: sync_pulse=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Monitor: pops one expectation per cycle and compares
    always @(negedge clk) begin
        if (running && q_exp.size() > 0) begin
            check(sync_pulse, q_exp.pop_front(), q_req.pop_front());
        end
    end

    // Driver: one cycle of stimulus plus the expected output it should cause
    task automatic step(input bit ctrl, input bit wr, input int wval);
        bit tick;
        bit exp;
        @(negedge clk);
        #1;
        tick       = (phase == 9);
        phase      = (phase + 1) % 10;
        ref_tick   = tick;
        sync_ctrl  = ctrl;
        ratio_wr   = wr;
        ratio_data = 8'(wval);
        exp = 1'b0;
        if (tick) begin
            if (m_s1 || m_armed || m_left == 0) begin
                exp    = 1'b1;
                m_n    = m_next;
                m_left = m_next - 1;
            end else begin
                m_left--;
            end
            m_armed = 1'b0;
        end else if (m_s1) begin
            m_armed = 1'b1;
        end
        if (wr && wval != 0) m_next = wval;
        m_s1 = m_s0;
        m_s0 = ctrl;
        q_exp.push_back(exp);
        q_req.push_back(cur_req);
    endtask

    task automatic run(input int cycles, input bit ctrl);
        for (int i = 0; i < cycles; i++) step(ctrl, 1'b0, 0);
    endtask

    task automatic set_ratio(input int v);
        step(1'b0, 1'b1, v);
    endtask

    initial begin
        rst = 1'b1; ref_tick = 0; sync_ctrl = 0; ratio_wr = 0; ratio_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sync_pulse, 1'b0, "R1");
        rst = 1'b0;
        running = 1'b1;
        cur_req = "R1";  run(12, 0);
        cur_req = "R4";  run(300, 0);
        cur_req = "R3";  set_ratio(3);  run(400, 0);
        cur_req = "R6";  run(15, 0); set_ratio(5); run(500, 0);
        cur_req = "R5";  run(13, 0); set_ratio(0); run(300, 0);
        cur_req = "R7";  set_ratio(7); run(147, 0); run(3, 1); run(400, 0);
        cur_req = "R8";  run(23, 0); run(200, 1); run(400, 0);
        cur_req = "R9";  set_ratio(255); run(5200, 0);
        cur_req = "R2";  set_ratio(2); run(200, 0);
        run(2, 0);
        running = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule